// File: doc/BRIEF.md
# Variable Page Size Data TLB

This block is a fully associative data translation buffer. Each entry maps one virtual page to a physical page, and each entry sets its own page size: 8 KB, 64 KB, 512 KB or 4 MB. Every lookup compares the request against all entries in the same cycle. The context used for the compare comes from the access class. An entry marked global matches in any context.

When an entry hits, the block checks the access against the entry's attribute flags. It then returns one of two things:
- a 41-bit page-aligned physical address with read and write permission, or
- a trap code.

On a fault, the block loads the fault status, fault address and tag-access registers. On a miss, it loads only the tag-access register. While translation is disabled, addresses pass straight through.

Entries are written through a direct indexed write port. An entry's used flag can be read back through an indexed read port. All lookup results are registered, so they appear one cycle after the request. Miss handling and refill belong to the surrounding logic.

Top module: `vpt_dtlb`

## Requirements
- R1: Size code 0, 1, 2 and 3 make an entry ignore virtual address bits [12:0], [15:0], [18:0] and [21:0] respectively when it compares its tag.
- R2: An entry hits only if it is valid, it matches in context, and its tag matches under its mask. It matches in context if its global flag is set or its context equals the lookup context. The lookup context is 13 bits and is picked by lk_class: 0 takes pri_ctx, 1 takes sec_ctx, and 2 or 3 take zero.
- R3: A hit returns a physical address made of two parts. Bits the mask keeps come from the entry's physical address. Bits the mask drops come from the virtual address. Bits [12:0] of the result are always zero.
- R4: When several entries hit, the entry with the lowest index supplies the result.
- R5: Three conditions on a hit are data faults. They are independent, so more than one may be flagged at once, and any of them gives rs_trap=2:
  - a user access to a privileged entry;
  - a non-faulting load (lk_kind=2) to a side-effect entry;
  - a load or store that is not a non-faulting load, to a no-fault-only entry.
- R6: A store (lk_kind=1) to an entry that is not writable gives rs_trap=3, but only when no R5 condition is present. In that case the fault-type bits of the status are zero.
- R7: Any fault (trap 2 or 3) loads the fault address register with the virtual address. It also replaces the status register with the bits below. Each bit not listed is zero.

  | Bit(s) | Meaning |
  |---|---|
  | 0 | Valid, always set |
  | 1 | Overflow, set if bit 0 was already set |
  | 2 | Store |
  | 3 | Non-faulting load |
  | [5:4] | lk_class |
  | 6 | priv_mode |
  | 7 | Privilege fault |
  | 8 | Side-effect fault |
  | 9 | No-fault-only fault |
- R8: A miss gives rs_trap=1 and leaves the status and fault address registers unchanged.
- R9: A miss or a fault loads the tag-access register with the virtual address, with bits [12:0] replaced by the lookup context.
- R10: A hit with no trap does three things. It gives rs_trap=0 and rs_rd=1. It sets rs_wr to the entry's writable flag. It sets the entry's used flag, which rd_used then shows. Writing an entry clears its used flag.
- R11: With tlb_en low, a lookup returns lk_va[40:0] unchanged with read and write permission and rs_trap=0. It changes no status register.
- R12: Results appear in the cycle after lk_req. rs_valid is high for exactly the cycles that follow a cycle in which lk_req was high.
- R13: After reset, all entries are invalid and all status registers and outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tlb_en | input | 1 | Translation enable |
| pri_ctx | input | 13 | Primary context |
| sec_ctx | input | 13 | Secondary context |
| priv_mode | input | 1 | Processor is in privileged mode |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| lk_class | input | 2 | 0 primary, 1 secondary, 2 nucleus |
| lk_user | input | 1 | User-mode access |
| lk_kind | input | 2 | 0 load, 1 store, 2 non-faulting load |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_vpn | input | 51 | Virtual address bits [63:13] for the tag |
| wr_ctx | input | 13 | Entry context |
| wr_pa | input | 41 | Entry physical address |
| wr_size | input | 2 | Page size code |
| wr_valid | input | 1 | Entry valid |
| wr_global | input | 1 | Entry ignores context |
| wr_priv | input | 1 | Entry is privileged |
| wr_wok | input | 1 | Entry is writable |
| wr_side | input | 1 | Entry has side effects |
| wr_nfo | input | 1 | Entry is no-fault-only |
| rd_idx | input | 6 | Entry index for used-flag read |
| rd_used | output | 1 | Used flag of entry rd_idx |
| rs_valid | output | 1 | Result valid |
| rs_trap | output | 2 | 0 none, 1 miss, 2 data fault, 3 protection |
| rs_pa | output | 41 | Physical address |
| rs_rd | output | 1 | Read permitted |
| rs_wr | output | 1 | Write permitted |
| sfsr_q | output | 10 | Fault status register |
| sfar_q | output | 64 | Fault address register |
| tag_acc_q | output | 64 | Tag-access register |

## Verification
Corrupt mask or context state in an entry would show up at the port in the very next result cycle. It appears as a miss where a hit was due, or as physical address bits taken from the wrong source.

A wrong overflow or fault-type bit shows up in sfsr_q in the cycle after the faulting lookup. A wrong overflow bit is caught only by a second fault, so the tests chain faults in sequence.

A lost used-flag update is visible at once through rd_used. A wrong priority choice is visible through the distinct physical addresses given to overlapping entries.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  localparam int PG_SHIFT  = 13;
  localparam int SIZE_SPAN = 9;   // VA bits [21:13] depend on the size code
  localparam int SFSR_W    = 10;

  localparam int SF_VALID   = 0;
  localparam int SF_OVF     = 1;
  localparam int SF_WRITE   = 2;
  localparam int SF_NF      = 3;
  localparam int SF_CLS     = 4;
  localparam int SF_PRIV    = 6;
  localparam int SF_FT_PRIV = 7;
  localparam int SF_FT_SIDE = 8;
  localparam int SF_FT_NFO  = 9;

  localparam logic [1:0] KIND_LOAD   = 2'd0;
  localparam logic [1:0] KIND_STORE  = 2'd1;
  localparam logic [1:0] KIND_NFLOAD = 2'd2;

  typedef enum logic [1:0] {
    TRAP_NONE   = 2'd0,
    TRAP_MISS   = 2'd1,
    TRAP_DFAULT = 2'd2,
    TRAP_PROT   = 2'd3
  } trap_e;

  // A set bit means that VA bit [13+i] takes part in the compare.
  function automatic logic [SIZE_SPAN-1:0] size_keep(input logic [1:0] sz);
    case (sz)
      2'd0:    size_keep = 9'h1FF;
      2'd1:    size_keep = 9'h1F8;
      2'd2:    size_keep = 9'h1C0;
      default: size_keep = 9'h000;
    endcase
  endfunction
endpackage

// File: rtl/vpt_entry_match.sv
module vpt_entry_match
  import vpt_pkg::*;
#(
  parameter int VPN_W = 51,
  parameter int CTX_W = 13
) (
  input  logic             e_valid,
  input  logic             e_glob,
  input  logic [1:0]       e_size,
  input  logic [VPN_W-1:0] e_vpn,
  input  logic [CTX_W-1:0] e_ctx,
  input  logic [VPN_W-1:0] q_vpn,
  input  logic [CTX_W-1:0] q_ctx,
  output logic             hit
);
  logic [VPN_W-1:0] cmp_mask;
  logic             ctx_ok;
  logic             tag_ok;

  always_comb begin
    cmp_mask                = '1;
    cmp_mask[SIZE_SPAN-1:0] = size_keep(e_size);
  end

  assign ctx_ok = e_glob || (e_ctx == q_ctx);
  assign tag_ok = ((e_vpn ^ q_vpn) & cmp_mask) == '0;
  assign hit    = e_valid && ctx_ok && tag_ok;
endmodule

// File: rtl/vpt_pick.sv
module vpt_pick #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] hit_vec,
  output logic               hit_any,
  output logic [IDX_W-1:0]   hit_idx
);
  always_comb begin
    hit_any = |hit_vec;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vpt_access_chk.sv
module vpt_access_chk
  import vpt_pkg::*;
(
  input  logic [1:0]        kind,
  input  logic              user,
  input  logic              priv_mode,
  input  logic              old_valid,
  input  logic [1:0]        cls,
  input  logic              e_priv,
  input  logic              e_wok,
  input  logic              e_side,
  input  logic              e_nfo,
  output trap_e             trap,
  output logic [SFSR_W-1:0] sfsr_val
);
  logic is_store, is_nf, ft_priv, ft_side, ft_nfo, any_ft;

  always_comb begin
    is_store = (kind == KIND_STORE);
    is_nf    = (kind == KIND_NFLOAD);
    ft_priv  = e_priv & user;
    ft_side  = is_nf & e_side;
    ft_nfo   = ~is_nf & e_nfo;
    any_ft   = ft_priv | ft_side | ft_nfo;

    if (any_ft)                  trap = TRAP_DFAULT;
    else if (is_store && !e_wok) trap = TRAP_PROT;
    else                         trap = TRAP_NONE;

    sfsr_val               = '0;
    sfsr_val[SF_VALID]     = 1'b1;
    sfsr_val[SF_OVF]       = old_valid;
    sfsr_val[SF_WRITE]     = is_store;
    sfsr_val[SF_NF]        = is_nf;
    sfsr_val[SF_CLS +: 2]  = cls;
    sfsr_val[SF_PRIV]      = priv_mode;
    sfsr_val[SF_FT_PRIV]   = ft_priv;
    sfsr_val[SF_FT_SIDE]   = ft_side;
    sfsr_val[SF_FT_NFO]    = ft_nfo;
  end
endmodule

// File: rtl/vpt_dtlb.sv
module vpt_dtlb
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 64,
  parameter int PA_W    = 41,
  parameter int CTX_W   = 13,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VPN_W  = VA_W - PG_SHIFT,
  localparam int PPN_W  = PA_W - PG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tlb_en,
  input  logic [CTX_W-1:0]  pri_ctx,
  input  logic [CTX_W-1:0]  sec_ctx,
  input  logic              priv_mode,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [1:0]        lk_class,
  input  logic              lk_user,
  input  logic [1:0]        lk_kind,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [CTX_W-1:0]  wr_ctx,
  input  logic [PA_W-1:0]   wr_pa,
  input  logic [1:0]        wr_size,
  input  logic              wr_valid,
  input  logic              wr_global,
  input  logic              wr_priv,
  input  logic              wr_wok,
  input  logic              wr_side,
  input  logic              wr_nfo,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_used,
  output logic              rs_valid,
  output logic [1:0]        rs_trap,
  output logic [PA_W-1:0]   rs_pa,
  output logic              rs_rd,
  output logic              rs_wr,
  output logic [SFSR_W-1:0] sfsr_q,
  output logic [VA_W-1:0]   sfar_q,
  output logic [VA_W-1:0]   tag_acc_q
);
  // Entry storage
  logic [ENTRIES-1:0] e_valid, e_glob, e_priv, e_wok, e_side, e_nfo, e_used;
  logic [ENTRIES-1:0] e_valid_d, e_used_d;
  logic [1:0]         e_size [ENTRIES];
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [CTX_W-1:0]   e_ctx  [ENTRIES];
  logic [PPN_W-1:0]   e_ppn  [ENTRIES];

  // Lookup datapath
  logic [CTX_W-1:0]   lk_ctx;
  logic [VPN_W-1:0]   q_vpn;
  logic [ENTRIES-1:0] hit_vec;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;
  logic [SIZE_SPAN-1:0] keep;
  logic [PPN_W-1:0]   ppn_mix;
  trap_e              chk_trap;
  logic [SFSR_W-1:0]  chk_sfsr;

  // Next-state values
  trap_e              n_trap;
  logic [PA_W-1:0]    n_pa;
  logic               n_rd, n_wr, upd_fault, upd_tag, set_used;
  trap_e              rs_trap_q;

  always_comb begin
    case (lk_class)
      2'd0:    lk_ctx = pri_ctx;
      2'd1:    lk_ctx = sec_ctx;
      default: lk_ctx = '0;
    endcase
  end

  assign q_vpn = lk_va[VA_W-1:PG_SHIFT];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    vpt_entry_match #(.VPN_W(VPN_W), .CTX_W(CTX_W)) u_match (
      .e_valid (e_valid[g]),
      .e_glob  (e_glob[g]),
      .e_size  (e_size[g]),
      .e_vpn   (e_vpn[g]),
      .e_ctx   (e_ctx[g]),
      .q_vpn   (q_vpn),
      .q_ctx   (lk_ctx),
      .hit     (hit_vec[g])
    );
  end

  vpt_pick #(.ENTRIES(ENTRIES)) u_pick (
    .hit_vec (hit_vec),
    .hit_any (hit_any),
    .hit_idx (hit_idx)
  );

  vpt_access_chk u_chk (
    .kind      (lk_kind),
    .user      (lk_user),
    .priv_mode (priv_mode),
    .old_valid (sfsr_q[SF_VALID]),
    .cls       (lk_class),
    .e_priv    (e_priv[hit_idx]),
    .e_wok     (e_wok[hit_idx]),
    .e_side    (e_side[hit_idx]),
    .e_nfo     (e_nfo[hit_idx]),
    .trap      (chk_trap),
    .sfsr_val  (chk_sfsr)
  );

  // Physical page: masked-out low page bits come from the VA
  always_comb begin
    keep    = size_keep(e_size[hit_idx]);
    ppn_mix = e_ppn[hit_idx];
    ppn_mix[SIZE_SPAN-1:0] = (e_ppn[hit_idx][SIZE_SPAN-1:0] & keep) |
                             (lk_va[PG_SHIFT +: SIZE_SPAN] & ~keep);
  end

  always_comb begin
    n_trap    = TRAP_NONE;
    n_pa      = '0;
    n_rd      = 1'b0;
    n_wr      = 1'b0;
    upd_fault = 1'b0;
    upd_tag   = 1'b0;
    set_used  = 1'b0;
    if (!tlb_en) begin
      n_pa = lk_va[PA_W-1:0];
      n_rd = 1'b1;
      n_wr = 1'b1;
    end else if (!hit_any) begin
      n_trap  = TRAP_MISS;
      upd_tag = 1'b1;
    end else if (chk_trap != TRAP_NONE) begin
      n_trap    = chk_trap;
      upd_tag   = 1'b1;
      upd_fault = 1'b1;
    end else begin
      n_pa     = {ppn_mix, {PG_SHIFT{1'b0}}};
      n_rd     = 1'b1;
      n_wr     = e_wok[hit_idx];
      set_used = 1'b1;
    end
  end

  always_comb begin
    e_valid_d = e_valid;
    e_used_d  = e_used;
    if (lk_req && set_used) e_used_d[hit_idx] = 1'b1;
    if (wr_en) begin
      e_valid_d[wr_idx] = wr_valid;
      e_used_d[wr_idx]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid <= '0;
      e_used  <= '0;
    end else begin
      e_valid <= e_valid_d;
      e_used  <= e_used_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      e_glob[wr_idx] <= wr_global;
      e_priv[wr_idx] <= wr_priv;
      e_wok[wr_idx]  <= wr_wok;
      e_side[wr_idx] <= wr_side;
      e_nfo[wr_idx]  <= wr_nfo;
      e_size[wr_idx] <= wr_size;
      e_vpn[wr_idx]  <= wr_vpn;
      e_ctx[wr_idx]  <= wr_ctx;
      e_ppn[wr_idx]  <= wr_pa[PA_W-1:PG_SHIFT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid  <= 1'b0;
      rs_trap_q <= TRAP_NONE;
      rs_pa     <= '0;
      rs_rd     <= 1'b0;
      rs_wr     <= 1'b0;
      sfsr_q    <= '0;
      sfar_q    <= '0;
      tag_acc_q <= '0;
    end else begin
      rs_valid <= lk_req;
      if (lk_req) begin
        rs_trap_q <= n_trap;
        rs_pa     <= n_pa;
        rs_rd     <= n_rd;
        rs_wr     <= n_wr;
      end
      if (lk_req && upd_fault) begin
        sfsr_q <= chk_sfsr;
        sfar_q <= lk_va;
      end
      if (lk_req && upd_tag) tag_acc_q <= {lk_va[VA_W-1:PG_SHIFT], lk_ctx};
    end
  end

  assign rs_trap = rs_trap_q;
  assign rd_used = e_used[rd_idx];

  // Assertions
  p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rs_valid);

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rs_valid);

  p_pick_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> (hit_vec[hit_idx] &&
                 ((hit_vec & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0)));

  p_miss_keeps_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_trap_q == TRAP_MISS) |-> ($stable(sfsr_q) && $stable(sfar_q)));

  p_fault_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_trap_q[1]) |-> (sfsr_q[SF_VALID] && sfar_q == $past(lk_va)));

  p_prot_no_ft_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_trap_q == TRAP_PROT) |-> (sfsr_q[SF_FT_NFO:SF_FT_PRIV] == '0));

  p_hit_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_trap_q == TRAP_NONE && $past(tlb_en)) |-> (rs_pa[PG_SHIFT-1:0] == '0));
endmodule

// File: tb/sim_vpt_dtlb.sv
module sim_vpt_dtlb;
  logic clk = 1'b0;
  logic rst_n;
  logic tlb_en;
  logic [12:0] pri_ctx, sec_ctx;
  logic priv_mode;
  logic lk_req;
  logic [63:0] lk_va;
  logic [1:0] lk_class, lk_kind;
  logic lk_user;
  logic wr_en;
  logic [5:0] wr_idx, rd_idx;
  logic [50:0] wr_vpn;
  logic [12:0] wr_ctx;
  logic [40:0] wr_pa;
  logic [1:0] wr_size;
  logic wr_valid, wr_global, wr_priv, wr_wok, wr_side, wr_nfo;
  logic rd_used, rs_valid, rs_rd, rs_wr;
  logic [1:0] rs_trap;
  logic [40:0] rs_pa;
  logic [9:0] sfsr_q;
  logic [63:0] sfar_q, tag_acc_q;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vpt_dtlb u0 (
    .clk(clk), .rst_n(rst_n), .tlb_en(tlb_en), .pri_ctx(pri_ctx), .sec_ctx(sec_ctx),
    .priv_mode(priv_mode), .lk_req(lk_req), .lk_va(lk_va), .lk_class(lk_class),
    .lk_user(lk_user), .lk_kind(lk_kind), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_ctx(wr_ctx), .wr_pa(wr_pa), .wr_size(wr_size),
    .wr_valid(wr_valid), .wr_global(wr_global), .wr_priv(wr_priv), .wr_wok(wr_wok),
    .wr_side(wr_side), .wr_nfo(wr_nfo), .rd_idx(rd_idx), .rd_used(rd_used),
    .rs_valid(rs_valid), .rs_trap(rs_trap), .rs_pa(rs_pa), .rs_rd(rs_rd),
    .rs_wr(rs_wr), .sfsr_q(sfsr_q), .sfar_q(sfar_q), .tag_acc_q(tag_acc_q)
  );

  localparam logic [40:0] PBASE = 41'h123_457F_E000;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [40:0] exp_pa(input logic [40:0] pa, input logic [63:0] va,
                                         input int sz);
    int b;
    logic [40:0] lowm;
    b = (sz == 0) ? 13 : (sz == 1) ? 16 : (sz == 2) ? 19 : 22;
    lowm = (41'h1 << b) - 41'h1;
    return ((pa & ~lowm) | (va[40:0] & lowm)) & ~41'h1FFF;
  endfunction

  task automatic put(input int idx, input logic [63:0] va, input logic [12:0] ctx,
                     input logic [40:0] pa, input logic [1:0] sz, input logic v,
                     input logic g, input logic p, input logic w, input logic s,
                     input logic n);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_vpn = va[63:13]; wr_ctx = ctx; wr_pa = pa;
    wr_size = sz; wr_valid = v; wr_global = g; wr_priv = p; wr_wok = w;
    wr_side = s; wr_nfo = n;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [63:0] va, input logic [1:0] cls, input logic usr,
                      input logic [1:0] kind);
    @(negedge clk);
    lk_req = 1'b1; lk_va = va; lk_class = cls; lk_user = usr; lk_kind = kind;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic t_reset;
    check("R13 sfsr", 64'(sfsr_q), 0);
    check("R13 sfar", sfar_q, 0);
    check("R13 tag", tag_acc_q, 0);
    check("R13 rs_valid", 64'(rs_valid), 0);
    look(64'h0, 2'd0, 1'b0, 2'd0);
    check("R13 empty miss", 64'(rs_trap), 1);
  endtask

  task automatic t_sizes;
    logic [63:0] va;
    for (int sz = 0; sz < 4; sz++) begin
      logic [63:0] tag;
      tag = {4'(sz + 1), 60'h0000_0000_0400_000};
      put(10 + sz, tag, 13'h5, PBASE, 2'(sz), 1, 0, 0, 1, 0, 0);
      va = tag | (64'h3F_FFFF >> (9 - 3 * sz)) & 64'h3F_FF01;
      va = tag + ((sz == 0) ? 64'h123 : (sz == 1) ? 64'hE456 :
                  (sz == 2) ? 64'h7_F123 : 64'h3F_F001);
      look(va, 2'd0, 1'b0, 2'd0);
      check("R1 size hit trap", 64'(rs_trap), 0);
      check("R3 pa", 64'(rs_pa), 64'(exp_pa(PBASE, va, sz)));
      va = tag + ((sz == 0) ? 64'h2000 : (sz == 1) ? 64'h1_0000 :
                  (sz == 2) ? 64'h8_0000 : 64'h40_0000);
      look(va, 2'd0, 1'b0, 2'd0);
      check("R1 outside page miss", 64'(rs_trap), 1);
    end
  endtask

  task automatic t_context;
    logic [9:0] s0;
    logic [63:0] a0;
    put(20, 64'h5000_0000_0000_0000, 13'h9, PBASE, 2'd0, 1, 0, 0, 1, 0, 0);
    put(21, 64'h6000_0000_0000_0000, 13'h0, PBASE, 2'd0, 1, 1, 0, 1, 0, 0);
    put(22, 64'h7000_0000_0000_0000, 13'h0, PBASE, 2'd0, 1, 0, 0, 1, 0, 0);
    put(23, 64'h8000_0000_0000_0000, 13'h5, PBASE, 2'd0, 0, 0, 0, 1, 0, 0);
    s0 = sfsr_q; a0 = sfar_q;
    look(64'h5000_0000_0000_0ABC, 2'd0, 1'b0, 2'd0);
    check("R2 primary ctx mismatch miss", 64'(rs_trap), 1);
    check("R9 miss tag access", tag_acc_q, 64'h5000_0000_0000_0005);
    check("R8 sfsr unchanged", 64'(sfsr_q), 64'(s0));
    check("R8 sfar unchanged", sfar_q, a0);
    look(64'h5000_0000_0000_0ABC, 2'd1, 1'b0, 2'd0);
    check("R2 secondary ctx hit", 64'(rs_trap), 0);
    look(64'h5000_0000_0000_0ABC, 2'd2, 1'b0, 2'd0);
    check("R2 nucleus miss", 64'(rs_trap), 1);
    check("R9 nucleus ctx zero", tag_acc_q, 64'h5000_0000_0000_0000);
    look(64'h6000_0000_0000_0100, 2'd0, 1'b0, 2'd0);
    check("R2 global hit", 64'(rs_trap), 0);
    look(64'h7000_0000_0000_0100, 2'd2, 1'b0, 2'd0);
    check("R2 nucleus ctx0 hit", 64'(rs_trap), 0);
    look(64'h7000_0000_0000_0100, 2'd0, 1'b0, 2'd0);
    check("R2 ctx0 entry primary miss", 64'(rs_trap), 1);
    look(64'h8000_0000_0000_0100, 2'd0, 1'b0, 2'd0);
    check("R2 invalid entry miss", 64'(rs_trap), 1);
  endtask

  task automatic t_priority;
    put(30, 64'h9000_0000_0000_0000, 13'h5, 41'h0AA_0000_0000, 2'd0, 1, 0, 0, 1, 0, 0);
    put(31, 64'h9000_0000_0000_0000, 13'h5, 41'h0BB_0000_0000, 2'd0, 1, 0, 0, 1, 0, 0);
    put(35, 64'h9000_0000_0000_0000, 13'h5, 41'h0CC_0000_0000, 2'd3, 1, 0, 0, 1, 0, 0);
    look(64'h9000_0000_0000_0010, 2'd0, 1'b0, 2'd0);
    check("R4 lowest index wins", 64'(rs_pa), 64'h0AA_0000_0000);
    put(30, 64'h9000_0000_0000_0000, 13'h5, 41'h0AA_0000_0000, 2'd0, 0, 0, 0, 1, 0, 0);
    look(64'h9000_0000_0000_0010, 2'd0, 1'b0, 2'd0);
    check("R4 next lowest wins", 64'(rs_pa), 64'h0BB_0000_0000);
  endtask

  task automatic t_faults;
    put(50, 64'hA000_0000_0000_0000, 13'h5, PBASE, 2'd0, 1, 0, 1, 0, 1, 1);
    priv_mode = 1'b1;
    look(64'hA000_0000_0000_0044, 2'd0, 1'b1, 2'd0);
    check("R5 priv+nfo trap", 64'(rs_trap), 2);
    check("R7 first sfsr", 64'(sfsr_q), 64'h2C1);
    check("R7 sfar", sfar_q, 64'hA000_0000_0000_0044);
    check("R9 fault tag access", tag_acc_q, 64'hA000_0000_0000_0005);
    priv_mode = 1'b0;
    look(64'hA000_0000_0000_0088, 2'd0, 1'b1, 2'd2);
    check("R5 nf load side-effect", 64'(rs_trap), 2);
    check("R7 overflow sfsr", 64'(sfsr_q), 64'h18B);
    look(64'hA000_0000_0000_00C0, 2'd0, 1'b0, 2'd1);
    check("R5 store nfo fault before prot", 64'(rs_trap), 2);
    check("R7 store sfsr", 64'(sfsr_q), 64'h207);
    put(53, 64'hD000_0000_0000_0000, 13'h0, PBASE, 2'd0, 1, 1, 1, 1, 0, 0);
    look(64'hD000_0000_0000_0100, 2'd1, 1'b1, 2'd0);
    check("R7 class field", 64'(sfsr_q), 64'h93);
    check("R9 secondary ctx tag", tag_acc_q, 64'hD000_0000_0000_0009);
  endtask

  task automatic t_prot;
    put(51, 64'hB000_0000_0000_0000, 13'h5, PBASE, 2'd0, 1, 0, 0, 0, 0, 0);
    look(64'hB000_0000_0000_0004, 2'd0, 1'b1, 2'd1);
    check("R6 prot trap", 64'(rs_trap), 3);
    check("R6 prot sfsr", 64'(sfsr_q), 64'h7);
    look(64'hB000_0000_0000_0004, 2'd0, 1'b1, 2'd0);
    check("R10 ro load trap", 64'(rs_trap), 0);
    check("R10 ro perms", 64'({rs_rd, rs_wr}), 64'b10);
  endtask

  task automatic t_used;
    put(52, 64'hC000_0000_0000_0000, 13'h5, PBASE, 2'd1, 1, 0, 0, 1, 0, 0);
    rd_idx = 6'd52;
    #1;
    check("R10 used clear after write", 64'(rd_used), 0);
    look(64'hC000_0000_0000_2000, 2'd0, 1'b1, 2'd1);
    check("R10 store hit trap", 64'(rs_trap), 0);
    check("R10 rw perms", 64'({rs_rd, rs_wr}), 64'b11);
    check("R10 used set", 64'(rd_used), 1);
    put(52, 64'hC000_0000_0000_0000, 13'h5, PBASE, 2'd1, 1, 0, 0, 1, 0, 0);
    #1;
    check("R10 used cleared by rewrite", 64'(rd_used), 0);
  endtask

  task automatic t_disabled;
    logic [9:0] s0;
    logic [63:0] t0;
    s0 = sfsr_q; t0 = tag_acc_q;
    tlb_en = 1'b0;
    look(64'hFFFF_FFFF_FFFF_F123, 2'd0, 1'b1, 2'd1);
    check("R11 pass pa", 64'(rs_pa), 64'h1FF_FFFF_F123);
    check("R11 trap none", 64'(rs_trap), 0);
    check("R11 perms", 64'({rs_rd, rs_wr}), 64'b11);
    check("R11 sfsr kept", 64'(sfsr_q), 64'(s0));
    check("R11 tag kept", tag_acc_q, t0);
    tlb_en = 1'b1;
  endtask

  task automatic t_latency;
    look(64'h6000_0000_0000_0000, 2'd0, 1'b0, 2'd0);
    check("R12 valid after request", 64'(rs_valid), 1);
    @(negedge clk);
    check("R12 valid drops", 64'(rs_valid), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tlb_en = 1'b1; pri_ctx = 13'h5; sec_ctx = 13'h9; priv_mode = 1'b0;
    lk_req = 1'b0; lk_va = '0; lk_class = '0; lk_user = 1'b0; lk_kind = '0;
    wr_en = 1'b0; wr_idx = '0; wr_vpn = '0; wr_ctx = '0; wr_pa = '0; wr_size = '0;
    wr_valid = 1'b0; wr_global = 1'b0; wr_priv = 1'b0; wr_wok = 1'b0;
    wr_side = 1'b0; wr_nfo = 1'b0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_context();
    t_priority();
    t_faults();
    t_prot();
    t_used();
    t_disabled();
    t_latency();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule